// File: doc/BRIEF.md
# Subsystem Control Register Bank

This block is the control register bank of a small two-core processor subsystem. It sits in a 4 KB window on a simple bus. A bus master raises `busValid` for one cycle, with `busWrite` choosing the direction. It stores debug-enable flags, a reset-cause word, a reset mask, a retention word, one boot vector per core, the per-core hold (wait) bits, and a few clock, wake and power-sense words. These words are plain storage: the bank does no clock division, power sequencing or reset-cause capture itself.

The bank has three side effects. When a hold bit is cleared, it sends a one-cycle release pulse to that core. A write to the software reset word can raise a one-cycle system reset request. Both boot vectors are also driven out as ports. A fixed set of identification words sits at the top of the window.

The `VERSION` parameter selects the variant. When bits 31:28 of `VERSION` equal 2, the block is the full variant. Any other value gives a reduced variant, in which several words are not decoded. The address is a word index: the byte offset is `busAddr * 4`. Narrow writes reach the bank as full words, with the unused lanes set to zero.

Top module: `subsys_ctl_bank`

## Requirements
- R1: After reset, the following values hold. The cause word (0x100) reads 1. The system power word (0x200) reads 0x7F. The core 0 vector (0x110) reads `VEC0_RST` and the core 1 vector (0x114) reads `VEC1_RST`, both defaulting to 0x10000000. The hold word (0x118) reads `WAIT_RST`, defaulting to 0. Every other stored word reads 0.
- R2: The following words store a full 32-bit write and read it back:
  - 0x00C, 0x010, 0x014, 0x018
  - 0x100, 0x104, 0x10C, 0x110, 0x114, 0x118, 0x11C
  - 0x120, 0x124, 0x200
  - 0x20C, 0x210, 0x214, 0x218

  `busRdata` holds the read value in the cycle after the read strobe.
- R3: The debug status word at 0x000 is read-only. A write to 0x004 ORs its data into that word. A write to 0x008 clears each status bit written as 1. Reads of 0x004, 0x008 and 0x108 return 0.
- R4: A write to 0x108 with data bit 9 set drives `sysResetReq` high for the single cycle after the write. With bit 9 clear, the write causes no request. The word stores nothing.
- R5: A write to 0x118 that moves hold bit 0 from 1 to 0 drives `coreRelease[0]` high for the single cycle after the write. Bit 1 does the same for `coreRelease[1]`. A bit that stays the same or goes from 0 to 1 gives no pulse.
- R6: The twelve words from 0xFD0 to 0xFFC read, in address order: 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these words have no effect.
- R7: In the reduced variant, the following offsets are invalid:
  - 0x00C, 0x010, 0x014, 0x018
  - 0x114, 0x124, 0x200
  - 0x20C to 0x218

  These offsets read 0 and ignore writes. Offsets outside the map are invalid in both variants.
- R8: In the reduced variant, 0x11C reads 0 without an error. A write to it is ignored and treated as a write to a read-only word.
- R9: `core0Vector` and `core1Vector` take a written value in the cycle after the write.
- R10: `busErr` pulses for the single cycle after any access to an invalid offset, and after any write to a read-only word (0x000 and the identification words). It stays low for every other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle decode error pulse |
| coreRelease | output | 2 | One-cycle release pulse per core |
| sysResetReq | output | 1 | One-cycle system reset request |
| core0Vector | output | 32 | Current core 0 boot vector |
| core1Vector | output | 32 | Current core 1 boot vector |

## Verification
Wrong internal state has two kinds of effect at the ports. A corrupted hold word shows up on the next write to 0x118: a release pulse is missing, or one appears that should not. A corrupted debug word shows up as a wrong set or clear result on the next status read. A wrong variant decode shows up in the cycle right after the access, as a stray or missing `busErr` pulse or as nonzero data from a word that should read zero. Stored values and boot vectors can be read back one cycle after any write, so a lost or misdirected write is visible as soon as the word is read.

// File: rtl/subsys_ctl_pkg.sv
package subsys_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 10;
  localparam int ID_W   = 4;
  localparam int ID_CNT = 12;
  localparam int SWRST_BIT = 9;
  localparam int NCORE = 2;

  typedef enum logic [4:0] {
    R_DBG, R_SEC, R_DIV0, R_DIV1, R_CFRC, R_SYND, R_RMSK, R_RET,
    R_VEC0, R_VEC1, R_WAIT, R_NMI, R_WIC, R_EWAK, R_PSYS,
    R_PSR0, R_PSR1, R_PSR2, R_PSR3
  } regIdx_e;
  localparam int NUM_REGS = 19;

  typedef enum logic [1:0] {SRC_ZERO, SRC_REG, SRC_ID} rdSrc_e;

  typedef struct packed {
    logic    wrStore;
    logic    dbgSet;
    logic    dbgClr;
    logic    swRst;
    logic    rdStrobe;
    rdSrc_e  rdSrc;
    regIdx_e idx;
    logic [ID_W-1:0] idIdx;
    logic    err;
  } ctlStb_t;

  localparam logic [WORD_W-1:0] W_DBG  = 10'h000;
  localparam logic [WORD_W-1:0] W_SET  = 10'h001;
  localparam logic [WORD_W-1:0] W_CLR  = 10'h002;
  localparam logic [WORD_W-1:0] W_SEC  = 10'h003;
  localparam logic [WORD_W-1:0] W_DIV0 = 10'h004;
  localparam logic [WORD_W-1:0] W_DIV1 = 10'h005;
  localparam logic [WORD_W-1:0] W_CFRC = 10'h006;
  localparam logic [WORD_W-1:0] W_SYND = 10'h040;
  localparam logic [WORD_W-1:0] W_RMSK = 10'h041;
  localparam logic [WORD_W-1:0] W_SWR  = 10'h042;
  localparam logic [WORD_W-1:0] W_RET  = 10'h043;
  localparam logic [WORD_W-1:0] W_VEC0 = 10'h044;
  localparam logic [WORD_W-1:0] W_VEC1 = 10'h045;
  localparam logic [WORD_W-1:0] W_WAIT = 10'h046;
  localparam logic [WORD_W-1:0] W_NMI  = 10'h047;
  localparam logic [WORD_W-1:0] W_WIC  = 10'h048;
  localparam logic [WORD_W-1:0] W_EWAK = 10'h049;
  localparam logic [WORD_W-1:0] W_PSYS = 10'h080;
  localparam logic [WORD_W-1:0] W_PSR0 = 10'h083;
  localparam logic [WORD_W-1:0] W_PSR1 = 10'h084;
  localparam logic [WORD_W-1:0] W_PSR2 = 10'h085;
  localparam logic [WORD_W-1:0] W_PSR3 = 10'h086;
  localparam logic [WORD_W-1:0] W_ID_FIRST = 10'h3F4;
endpackage

// File: rtl/subsys_ctl_decode.sv
module subsys_ctl_decode
  import subsys_ctl_pkg::*;
#(
  parameter logic [31:0] VERSION = 32'h2000_0000
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [WORD_W-1:0] busAddr,
  output ctlStb_t           stb
);
  localparam bit FULL = (VERSION[31:28] == 4'h2);

  typedef enum logic [2:0] {
    K_STORE, K_RO, K_SET, K_CLR, K_SWRST, K_ZERO, K_ID, K_BAD
  } kind_e;

  kind_e   kind;
  regIdx_e idx;
  logic    gated;

  always_comb begin
    kind  = K_STORE;
    idx   = R_DBG;
    gated = 1'b0;
    case (busAddr)
      W_DBG:  kind = K_RO;
      W_SET:  kind = K_SET;
      W_CLR:  kind = K_CLR;
      W_SWR:  kind = K_SWRST;
      W_SEC:  begin idx = R_SEC;  gated = 1'b1; end
      W_DIV0: begin idx = R_DIV0; gated = 1'b1; end
      W_DIV1: begin idx = R_DIV1; gated = 1'b1; end
      W_CFRC: begin idx = R_CFRC; gated = 1'b1; end
      W_SYND: idx = R_SYND;
      W_RMSK: idx = R_RMSK;
      W_RET:  idx = R_RET;
      W_VEC0: idx = R_VEC0;
      W_VEC1: begin idx = R_VEC1; gated = 1'b1; end
      W_WAIT: idx = R_WAIT;
      W_NMI:  begin idx = R_NMI; if (!FULL) kind = K_ZERO; end
      W_WIC:  idx = R_WIC;
      W_EWAK: begin idx = R_EWAK; gated = 1'b1; end
      W_PSYS: begin idx = R_PSYS; gated = 1'b1; end
      W_PSR0: begin idx = R_PSR0; gated = 1'b1; end
      W_PSR1: begin idx = R_PSR1; gated = 1'b1; end
      W_PSR2: begin idx = R_PSR2; gated = 1'b1; end
      W_PSR3: begin idx = R_PSR3; gated = 1'b1; end
      default: kind = (busAddr >= W_ID_FIRST) ? K_ID : K_BAD;
    endcase
    if (gated && !FULL) kind = K_BAD;
  end

  always_comb begin
    stb          = '0;
    stb.idx      = idx;
    stb.idIdx    = busAddr[ID_W-1:0] - ID_W'(4);
    stb.rdStrobe = busValid && !busWrite;
    stb.rdSrc    = (kind == K_STORE || kind == K_RO) ? SRC_REG :
                   (kind == K_ID) ? SRC_ID : SRC_ZERO;
    if (busValid && busWrite) begin
      stb.wrStore = (kind == K_STORE);
      stb.dbgSet  = (kind == K_SET);
      stb.dbgClr  = (kind == K_CLR);
      stb.swRst   = (kind == K_SWRST);
    end
    stb.err = busValid && ((kind == K_BAD) ||
              (busWrite && (kind == K_RO || kind == K_ID || kind == K_ZERO)));
  end
endmodule

// File: rtl/subsys_ctl_datapath.sv
module subsys_ctl_datapath
  import subsys_ctl_pkg::*;
#(
  parameter logic [31:0] VEC0_RST = 32'h1000_0000,
  parameter logic [31:0] VEC1_RST = 32'h1000_0000,
  parameter logic [31:0] WAIT_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic [NCORE-1:0]  coreRelease,
  output logic              sysResetReq,
  output logic [DATA_W-1:0] core0Vector,
  output logic [DATA_W-1:0] core1Vector
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  function automatic logic [DATA_W-1:0] rstValue(int i);
    case (i)
      int'(R_SYND): return 32'h1;
      int'(R_PSYS): return 32'h7F;
      int'(R_VEC0): return VEC0_RST;
      int'(R_VEC1): return VEC1_RST;
      int'(R_WAIT): return WAIT_RST;
      default:      return '0;
    endcase
  endfunction

  function automatic logic [7:0] idByte(logic [ID_W-1:0] k);
    case (k)
      4'd0:  return 8'h04;
      4'd4:  return 8'h54;
      4'd5:  return 8'hB8;
      4'd6:  return 8'h0B;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= rstValue(i);
      busRdata    <= '0;
      busErr      <= 1'b0;
      coreRelease <= '0;
      sysResetReq <= 1'b0;
    end else begin
      busErr      <= stb.err;
      sysResetReq <= stb.swRst && busWdata[SWRST_BIT];
      coreRelease <= '0;
      if (stb.wrStore) begin
        regs[stb.idx] <= busWdata;
        if (stb.idx == R_WAIT)
          coreRelease <= regs[R_WAIT][NCORE-1:0] & ~busWdata[NCORE-1:0];
      end
      if (stb.dbgSet) regs[R_DBG] <= regs[R_DBG] | busWdata;
      if (stb.dbgClr) regs[R_DBG] <= regs[R_DBG] & ~busWdata;
      if (stb.rdStrobe) begin
        case (stb.rdSrc)
          SRC_REG: busRdata <= regs[stb.idx];
          SRC_ID:  busRdata <= {{(DATA_W-8){1'b0}}, idByte(stb.idIdx)};
          default: busRdata <= '0;
        endcase
      end
    end
  end

  assign core0Vector = regs[R_VEC0];
  assign core1Vector = regs[R_VEC1];
endmodule

// File: rtl/subsys_ctl_bank.sv
module subsys_ctl_bank
  import subsys_ctl_pkg::*;
#(
  parameter logic [31:0] VERSION  = 32'h2000_0000,
  parameter logic [31:0] VEC0_RST = 32'h1000_0000,
  parameter logic [31:0] VEC1_RST = 32'h1000_0000,
  parameter logic [31:0] WAIT_RST = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [WORD_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic [NCORE-1:0]  coreRelease,
  output logic              sysResetReq,
  output logic [DATA_W-1:0] core0Vector,
  output logic [DATA_W-1:0] core1Vector
);
  ctlStb_t stb;

  subsys_ctl_decode #(.VERSION(VERSION)) u_decode (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .stb(stb)
  );

  subsys_ctl_datapath #(
    .VEC0_RST(VEC0_RST), .VEC1_RST(VEC1_RST), .WAIT_RST(WAIT_RST)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .coreRelease(coreRelease),
    .sysResetReq(sysResetReq), .core0Vector(core0Vector),
    .core1Vector(core1Vector)
  );
endmodule

// File: rtl/subsys_ctl_bank_chk.sv
module subsys_ctl_bank_chk
  import subsys_ctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [WORD_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic [NCORE-1:0]  coreRelease,
  input logic              sysResetReq,
  input logic [DATA_W-1:0] core0Vector
);
  AST_RELEASE_NEEDS_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|coreRelease) |-> $past(busValid && busWrite && busAddr == W_WAIT)); // R5

  AST_RESET_REQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(busValid && busWrite && busAddr == W_SWR && busWdata[SWRST_BIT])); // R4

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busValid)); // R10

  AST_VECTOR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid && busWrite) |-> $stable(core0Vector)); // R9

  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(busValid && !busWrite && (busAddr == W_SET || busAddr == W_CLR || busAddr == W_SWR))
      |-> busRdata == '0); // R3
endmodule

bind subsys_ctl_bank subsys_ctl_bank_chk u_chk (.*);

// File: tb/subsys_ctl_bank_bench.sv
module subsys_ctl_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        v0 = 0, w0 = 0, v1 = 0, w1 = 0;
  logic [9:0]  a0 = 0, a1 = 0;
  logic [31:0] d0 = 0, d1 = 0;
  logic [31:0] rd0, rd1, c0v0, c1v0, c0v1, c1v1;
  logic        err0, err1, srq0, srq1;
  logic [1:0]  rel0, rel1;

  int total = 0;
  int bad = 0;

  subsys_ctl_bank #(.VERSION(32'h2000_0001), .VEC1_RST(32'h2000_0000),
                    .WAIT_RST(32'h3)) u_subsys_ctl_bank (
    .clk(clk), .rstN(rstN), .busValid(v0), .busWrite(w0), .busAddr(a0),
    .busWdata(d0), .busRdata(rd0), .busErr(err0), .coreRelease(rel0),
    .sysResetReq(srq0), .core0Vector(c0v0), .core1Vector(c1v0));

  subsys_ctl_bank #(.VERSION(32'h1000_0000)) u_subsys_ctl_bank_lite (
    .clk(clk), .rstN(rstN), .busValid(v1), .busWrite(w1), .busAddr(a1),
    .busWdata(d1), .busRdata(rd1), .busErr(err1), .coreRelease(rel1),
    .sysResetReq(srq1), .core0Vector(c0v1), .core1Vector(c1v1));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(int u, bit wr, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    if (u == 0) begin v0 = 1; w0 = wr; a0 = a; d0 = d; end
    else        begin v1 = 1; w1 = wr; a1 = a; d1 = d; end
    @(negedge clk);
    v0 = 0; v1 = 0; w0 = 0; w1 = 0; d0 = 0; d1 = 0;
  endtask

  task automatic rdChk(int u, string tag, logic [9:0] a, logic [31:0] exp, bit expErr);
    access(u, 0, a, 0);
    chk(tag, (u == 0) ? rd0 : rd1, exp);
    chk({tag, " err"}, {31'b0, (u == 0) ? err0 : err1}, {31'b0, expErr});
  endtask

  task automatic tReset();
    chk("R1 vec0 port", c0v0, 32'h1000_0000);
    chk("R1 vec1 port", c1v0, 32'h2000_0000);
    rdChk(0, "R1 cause", 10'h040, 32'h1, 0);
    rdChk(0, "R1 psys", 10'h080, 32'h7F, 0);
    rdChk(0, "R1 hold", 10'h046, 32'h3, 0);
    rdChk(0, "R1 retain", 10'h043, 32'h0, 0);
    rdChk(0, "R1 debug", 10'h000, 32'h0, 0);
    rdChk(0, "R1 vec1", 10'h045, 32'h2000_0000, 0);
  endtask

  task automatic tStorage();
    access(0, 1, 10'h043, 32'hDEAD_BEEF);
    access(0, 1, 10'h005, 32'h0000_00A5);
    access(0, 1, 10'h086, 32'h8000_0001);
    access(0, 1, 10'h047, 32'h1);
    rdChk(0, "R2 retain", 10'h043, 32'hDEAD_BEEF, 0);
    rdChk(0, "R2 div1", 10'h005, 32'h0000_00A5, 0);
    rdChk(0, "R2 psr3", 10'h086, 32'h8000_0001, 0);
    rdChk(0, "R2 nmi", 10'h047, 32'h1, 0);
  endtask

  task automatic tDebug();
    access(0, 1, 10'h001, 32'h5);
    access(0, 1, 10'h001, 32'h30);
    rdChk(0, "R3 set", 10'h000, 32'h35, 0);
    access(0, 1, 10'h002, 32'h14);
    rdChk(0, "R3 clear", 10'h000, 32'h21, 0);
    access(0, 1, 10'h000, 32'hFFFF_FFFF);
    chk("R10 ro write err", {31'b0, err0}, 32'h1);
    rdChk(0, "R3 ro ignored", 10'h000, 32'h21, 0);
    rdChk(0, "R3 set alias reads 0", 10'h001, 32'h0, 0);
    rdChk(0, "R3 clr alias reads 0", 10'h002, 32'h0, 0);
  endtask

  task automatic tSwReset();
    access(0, 1, 10'h042, 32'h0000_0200);
    chk("R4 request", {31'b0, srq0}, 32'h1);
    @(negedge clk);
    chk("R4 one cycle", {31'b0, srq0}, 32'h0);
    access(0, 1, 10'h042, 32'hFFFF_FDFF);
    chk("R4 no bit9", {31'b0, srq0}, 32'h0);
    rdChk(0, "R4 reads 0", 10'h042, 32'h0, 0);
  endtask

  task automatic tRelease();
    access(0, 1, 10'h046, 32'h2);
    chk("R5 core0 release", {30'b0, rel0}, 32'h1);
    @(negedge clk);
    chk("R5 one cycle", {30'b0, rel0}, 32'h0);
    access(0, 1, 10'h046, 32'h0);
    chk("R5 core1 release", {30'b0, rel0}, 32'h2);
    access(0, 1, 10'h046, 32'h3);
    chk("R5 rise no pulse", {30'b0, rel0}, 32'h0);
    access(0, 1, 10'h046, 32'h3);
    chk("R5 unchanged no pulse", {30'b0, rel0}, 32'h0);
    access(0, 1, 10'h046, 32'h0);
    chk("R5 both release", {30'b0, rel0}, 32'h3);
    rdChk(0, "R5 hold readback", 10'h046, 32'h0, 0);
  endtask

  task automatic tVector();
    access(0, 1, 10'h044, 32'h0004_0000);
    chk("R9 vec0 port", c0v0, 32'h0004_0000);
    access(0, 1, 10'h045, 32'h0008_0000);
    chk("R9 vec1 port", c1v0, 32'h0008_0000);
  endtask

  task automatic tIds();
    logic [7:0] ids [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 12; k++)
      rdChk(0, "R6 id", 10'h3F4 + 10'(k), {24'b0, ids[k]}, 0);
    access(0, 1, 10'h3F8, 32'hFF);
    chk("R10 id write err", {31'b0, err0}, 32'h1);
    rdChk(0, "R6 id write ignored", 10'h3F8, 32'h54, 0);
  endtask

  task automatic tInvalid();
    rdChk(0, "R10 hole", 10'h0C0, 32'h0, 1);
    access(0, 1, 10'h0C0, 32'h1234);
    chk("R10 hole write err", {31'b0, err0}, 32'h1);
    access(0, 1, 10'h043, 32'h1);
    chk("R10 no err valid write", {31'b0, err0}, 32'h0);
  endtask

  task automatic tLite();
    access(1, 1, 10'h004, 32'h77);
    chk("R7 gated write err", {31'b0, err1}, 32'h1);
    rdChk(1, "R7 div0 reads 0", 10'h004, 32'h0, 1);
    access(1, 1, 10'h045, 32'h55);
    chk("R7 vec1 unchanged", c1v1, 32'h1000_0000);
    rdChk(1, "R7 vec1 reads 0", 10'h045, 32'h0, 1);
    rdChk(1, "R7 psys reads 0", 10'h080, 32'h0, 1);
    rdChk(1, "R7 psr0 reads 0", 10'h083, 32'h0, 1);
    access(1, 1, 10'h047, 32'h1);
    chk("R8 nmi write err", {31'b0, err1}, 32'h1);
    rdChk(1, "R8 nmi reads 0", 10'h047, 32'h0, 0);
    access(1, 1, 10'h044, 32'hABCD_0000);
    rdChk(1, "R7 vec0 still works", 10'h044, 32'hABCD_0000, 0);
    rdChk(1, "R7 cause still works", 10'h040, 32'h1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tStorage();
    tDebug();
    tSwReset();
    tRelease();
    tVector();
    tIds();
    tInvalid();
    tLite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule